// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block gathers interrupt events from four serial blocks, each serving two channels (eight channels in all), and turns them into two interrupt request lines. Every block owns an 8-bit status byte and an 8-bit mask byte. Per-channel set and clear pulses from the channel logic are routed into the status byte of the owning block. Channel parity picks which half of that byte a channel uses. A block-level counter event and an input-change event use the two remaining bits. A pair of blocks feeds each request line. The line is high while any unmasked status bit is set in either block of the pair.

The host reaches the block through three spaces. In the I/O space, a byte address is split into block, channel and register offset. The decoded fields are also output for the channel logic. One register offset reads the block status and writes the block mask. Writes to the ID space, and byte writes to the memory space, load an 8-bit interrupt vector. Reads in the interrupt space act as acknowledge cycles and return that vector.

Top module: `irq_aggregator`

## Requirements
- R1: The decode outputs follow the address with no clock delay: block = address bits 6:5, channel = address bits 6:4, register offset = address bits 4:0 XOR 1.
- R2: Channel c lands in the status byte of block c/2. An even channel uses bit 0 (transmit ready), bit 1 (receive ready) and bit 2 (break). An odd channel uses bits 4, 5 and 6 for the same events. A block's counter event sets bit 3 and its input-change event sets bit 7.
- R3: A clear pulse resets its status bit. When a set pulse and a clear pulse hit the same bit in the same cycle, the bit ends up set.
- R4: Request line 0 is high when (status AND mask) is nonzero in block 0 or block 1. Request line 1 does the same for blocks 2 and 3.
- R5: The request lines are registered. After a set pulse, the line changes on the second rising edge: the first edge updates status, the second updates the line. A mask write shows on the line one edge after the mask changes.
- R6: An I/O write at register offset 5 (address low bits 00100) loads that block's mask. Masks, status, vector and read data reset to zero, so both lines are low after reset.
- R7: An I/O read at register offset 5 returns the block status on the read data one cycle later and leaves the status unchanged. An I/O read at any other offset returns 0.
- R8: An ID-space write or a memory-space byte write loads the write data into the interrupt vector.
- R9: An interrupt-space read at address 0 or 2 returns the vector, and a read at any other address returns 0. Neither read changes the request lines.
- R10: An I/O access with address bit 7 set touches no mask, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | I/O-space write strobe |
| ioRd | input | 1 | I/O-space read strobe |
| idWr | input | 1 | ID-space write strobe |
| memWr8 | input | 1 | Memory-space byte write strobe |
| intRd | input | 1 | Interrupt-space (acknowledge) read strobe |
| hostAddr | input | 8 | Host byte address |
| hostWrData | input | 8 | Host write data |
| txSet | input | 8 | Per-channel transmit-ready set pulses |
| rxSet | input | 8 | Per-channel receive-ready set pulses |
| brkSet | input | 8 | Per-channel break set pulses |
| txClr | input | 8 | Per-channel transmit-ready clear pulses |
| rxClr | input | 8 | Per-channel receive-ready clear pulses |
| brkClr | input | 8 | Per-channel break clear pulses |
| cntSet | input | 4 | Per-block counter event set pulses |
| cntClr | input | 4 | Per-block counter event clear pulses |
| ipcSet | input | 4 | Per-block input-change set pulses |
| ipcClr | input | 4 | Per-block input-change clear pulses |
| irqReq | output | 2 | Registered interrupt request lines |
| rdData | output | 8 | Registered read data |
| decBlk | output | 2 | Decoded block index |
| decChan | output | 3 | Decoded channel index |
| decReg | output | 5 | Decoded register offset |

## Verification
Events are driven on even and odd channels of every block, and on the block-level bits. Status read-backs then tell a correct parity placement from a swapped one. Masks are enabled one block at a time, so a wrong pairing of blocks to lines shows up as a line that rises in the wrong place. Set and clear pulses are driven on the same bit in the same cycle to expose a reversed priority. An exact edge count on one event pins the registered line delay. Acknowledge reads at valid and invalid addresses, and accesses with address bit 7 set, show that vector loads, acknowledges and the out-of-range space leave masks and lines alone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_BLK  = 4;
  localparam int NUM_CH   = 2 * NUM_BLK;
  localparam int NUM_LINE = NUM_BLK / 2;
  localparam int BLK_W    = $clog2(NUM_BLK);
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int BYTE_W   = 8;
  localparam int OFS_W    = 5;
  localparam logic [OFS_W-1:0] STAT_OFS = 5'd5;

  typedef struct packed {
    logic             maskWe;
    logic             vecWe;
    logic             rdLoad;
    logic             rdStatus;
    logic             rdVector;
    logic [BLK_W-1:0] blk;
  } hostStrobeT;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioWr,
  input  logic                ioRd,
  input  logic                idWr,
  input  logic                memWr8,
  input  logic                intRd,
  input  logic [BYTE_W-1:0]   hostAddr,
  output hostStrobeT          stb,
  output logic [BLK_W-1:0]    decBlk,
  output logic [CH_W-1:0]     decChan,
  output logic [OFS_W-1:0]    decReg
);
  logic ioInRange;
  logic statHit;
  logic ackAddr;

  // R1: field split of the I/O address
  assign decBlk  = hostAddr[OFS_W+BLK_W-1:OFS_W];
  assign decChan = hostAddr[OFS_W+BLK_W-1:OFS_W-1];
  assign decReg  = hostAddr[OFS_W-1:0] ^ OFS_W'(1);

  assign ioInRange = !hostAddr[BYTE_W-1];
  assign statHit   = ioInRange && (decReg == STAT_OFS);
  assign ackAddr   = (hostAddr == 8'd0) || (hostAddr == 8'd2);

  always_comb begin
    stb          = '0;
    stb.blk      = decBlk;
    stb.maskWe   = ioWr && statHit;
    stb.vecWe    = idWr || memWr8;
    stb.rdLoad   = ioRd || intRd;
    stb.rdStatus = ioRd && statHit;
    stb.rdVector = intRd && !ioRd && ackAddr;
  end

  a_r7_one_read_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdStatus, stb.rdVector}));

  a_r10_high_space_ignored: assert property (@(posedge clk) disable iff (!rstN)
    hostAddr[BYTE_W-1] |-> (!stb.maskWe && !stb.rdStatus));

  a_r9_ack_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdVector |-> (intRd && stb.rdLoad));
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobeT          stb,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [NUM_CH-1:0]   txSet,
  input  logic [NUM_CH-1:0]   rxSet,
  input  logic [NUM_CH-1:0]   brkSet,
  input  logic [NUM_CH-1:0]   txClr,
  input  logic [NUM_CH-1:0]   rxClr,
  input  logic [NUM_CH-1:0]   brkClr,
  input  logic [NUM_BLK-1:0]  cntSet,
  input  logic [NUM_BLK-1:0]  cntClr,
  input  logic [NUM_BLK-1:0]  ipcSet,
  input  logic [NUM_BLK-1:0]  ipcClr,
  output logic [NUM_LINE-1:0] irqReq,
  output logic [BYTE_W-1:0]   rdData
);
  logic [BYTE_W-1:0] statusQ [NUM_BLK];
  logic [BYTE_W-1:0] maskQ   [NUM_BLK];
  logic [BYTE_W-1:0] setV    [NUM_BLK];
  logic [BYTE_W-1:0] clrV    [NUM_BLK];
  logic [BYTE_W-1:0] vecQ;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    // R2: odd channel in the upper nibble, even channel in the lower one
    assign setV[b] = {ipcSet[b], brkSet[2*b+1], rxSet[2*b+1], txSet[2*b+1],
                      cntSet[b], brkSet[2*b],   rxSet[2*b],   txSet[2*b]};
    assign clrV[b] = {ipcClr[b], brkClr[2*b+1], rxClr[2*b+1], txClr[2*b+1],
                      cntClr[b], brkClr[2*b],   rxClr[2*b],   txClr[2*b]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[b] <= '0;
        maskQ[b]   <= '0;
      end else begin
        statusQ[b] <= (statusQ[b] & ~clrV[b]) | setV[b];
        if (stb.maskWe && (stb.blk == BLK_W'(b))) maskQ[b] <= wrData;
      end
    end

    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (setV[b] != '0) |=> ((statusQ[b] & $past(setV[b])) == $past(setV[b])));

    a_r7_read_no_side_effect: assert property (@(posedge clk) disable iff (!rstN)
      (stb.rdStatus && setV[b] == '0 && clrV[b] == '0) |=> $stable(statusQ[b]));
  end

  for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) irqReq[l] <= 1'b0;
      else irqReq[l] <= |((statusQ[2*l] & maskQ[2*l]) | (statusQ[2*l+1] & maskQ[2*l+1]));
    end

    a_r4_masked_pair_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[2*l] == '0 && maskQ[2*l+1] == '0) |=> !irqReq[l]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ   <= '0;
      rdData <= '0;
    end else begin
      if (stb.vecWe) vecQ <= wrData;
      if (stb.rdLoad) begin
        if (stb.rdStatus)      rdData <= statusQ[stb.blk];
        else if (stb.rdVector) rdData <= vecQ;
        else                   rdData <= '0;
      end
    end
  end

  a_r8_vector_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.vecWe |=> $stable(vecQ));

  a_r9_rd_holds_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(rdData));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioWr,
  input  logic                ioRd,
  input  logic                idWr,
  input  logic                memWr8,
  input  logic                intRd,
  input  logic [BYTE_W-1:0]   hostAddr,
  input  logic [BYTE_W-1:0]   hostWrData,
  input  logic [NUM_CH-1:0]   txSet,
  input  logic [NUM_CH-1:0]   rxSet,
  input  logic [NUM_CH-1:0]   brkSet,
  input  logic [NUM_CH-1:0]   txClr,
  input  logic [NUM_CH-1:0]   rxClr,
  input  logic [NUM_CH-1:0]   brkClr,
  input  logic [NUM_BLK-1:0]  cntSet,
  input  logic [NUM_BLK-1:0]  cntClr,
  input  logic [NUM_BLK-1:0]  ipcSet,
  input  logic [NUM_BLK-1:0]  ipcClr,
  output logic [NUM_LINE-1:0] irqReq,
  output logic [BYTE_W-1:0]   rdData,
  output logic [BLK_W-1:0]    decBlk,
  output logic [CH_W-1:0]     decChan,
  output logic [OFS_W-1:0]    decReg
);
  hostStrobeT stb;

  irq_agg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .idWr(idWr),
    .memWr8(memWr8), .intRd(intRd), .hostAddr(hostAddr), .stb(stb),
    .decBlk(decBlk), .decChan(decChan), .decReg(decReg)
  );

  irq_agg_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(hostWrData),
    .txSet(txSet), .rxSet(rxSet), .brkSet(brkSet),
    .txClr(txClr), .rxClr(rxClr), .brkClr(brkClr),
    .cntSet(cntSet), .cntClr(cntClr), .ipcSet(ipcSet), .ipcClr(ipcClr),
    .irqReq(irqReq), .rdData(rdData)
  );
endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWr = 0, ioRd = 0, idWr = 0, memWr8 = 0, intRd = 0;
  logic [7:0] hostAddr = '0, hostWrData = '0;
  logic [7:0] txSet = '0, rxSet = '0, brkSet = '0, txClr = '0, rxClr = '0, brkClr = '0;
  logic [3:0] cntSet = '0, cntClr = '0, ipcSet = '0, ipcClr = '0;
  logic [1:0] irqReq;
  logic [7:0] rdData;
  logic [1:0] decBlk;
  logic [2:0] decChan;
  logic [4:0] decReg;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  string rdTag = "R7";

  always #2.5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .idWr(idWr),
    .memWr8(memWr8), .intRd(intRd), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .txSet(txSet), .rxSet(rxSet), .brkSet(brkSet),
    .txClr(txClr), .rxClr(rxClr), .brkClr(brkClr),
    .cntSet(cntSet), .cntClr(cntClr), .ipcSet(ipcSet), .ipcClr(ipcClr),
    .irqReq(irqReq), .rdData(rdData),
    .decBlk(decBlk), .decChan(decChan), .decReg(decReg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mSt[4], mMask[4];
  int mVec = 0, mRd = 0;
  int mIrq[2];

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mSt[i]) begin mSt[i] = 0; mMask[i] = 0; end
      mVec = 0; mRd = 0; mIrq[0] = 0; mIrq[1] = 0;
    end else begin
      int ofs, blk;
      for (int l = 0; l < 2; l++)
        mIrq[l] = (((mSt[2*l] & mMask[2*l]) | (mSt[2*l+1] & mMask[2*l+1])) != 0) ? 1 : 0;
      ofs = (hostAddr % 32) ^ 1;
      blk = (hostAddr / 32) % 4;
      if (ioRd)       mRd = (hostAddr < 128 && ofs == 5) ? mSt[blk] : 0;
      else if (intRd) mRd = (hostAddr == 0 || hostAddr == 2) ? mVec : 0;
      if (ioWr && hostAddr < 128 && ofs == 5) mMask[blk] = hostWrData;
      if (idWr || memWr8) mVec = hostWrData;
      for (int c = 0; c < 8; c++) begin
        int b, base;
        b = c / 2;
        base = (c % 2 == 1) ? 4 : 0;
        if (txClr[c])  mSt[b] &= ~(1 << base);
        if (rxClr[c])  mSt[b] &= ~(1 << (base + 1));
        if (brkClr[c]) mSt[b] &= ~(1 << (base + 2));
        if (txSet[c])  mSt[b] |= (1 << base);
        if (rxSet[c])  mSt[b] |= (1 << (base + 1));
        if (brkSet[c]) mSt[b] |= (1 << (base + 2));
      end
      for (int b = 0; b < 4; b++) begin
        if (cntClr[b]) mSt[b] &= ~8;
        if (ipcClr[b]) mSt[b] &= ~128;
        if (cntSet[b]) mSt[b] |= 8;
        if (ipcSet[b]) mSt[b] |= 128;
      end
    end
  end

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R4 R5 line 0", irqReq[0], mIrq[0]);
      chk("R4 R5 line 1", irqReq[1], mIrq[1]);
      chk(rdTag, rdData, mRd);
    end
  end

  task automatic clearInputs();
    ioWr = 0; ioRd = 0; idWr = 0; memWr8 = 0; intRd = 0;
    txSet = 0; rxSet = 0; brkSet = 0; txClr = 0; rxClr = 0; brkClr = 0;
    cntSet = 0; cntClr = 0; ipcSet = 0; ipcClr = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clearInputs();
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWrData = d; ioWr = 1;
    tick();
  endtask

  task automatic ioRead(input logic [7:0] a, input string tag);
    @(negedge clk); hostAddr = a; ioRd = 1; rdTag = tag;
    tick();
  endtask

  task automatic ackRead(input logic [7:0] a, input string tag);
    @(negedge clk); hostAddr = a; intRd = 1; rdTag = tag;
    tick();
  endtask

  task automatic decodeCheck(input logic [7:0] a);
    @(negedge clk); hostAddr = a; #1;
    chk("R1 block", decBlk, (a / 32) % 4);
    chk("R1 channel", decChan, (a / 16) % 8);
    chk("R1 offset", decReg, (a % 32) ^ 1);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset lines", irqReq, 0);
    chk("R6 reset read data", rdData, 0);
    rstN = 1;

    // R1 decode
    decodeCheck(8'h00); decodeCheck(8'h15); decodeCheck(8'h3A);
    decodeCheck(8'h4F); decodeCheck(8'h64); decodeCheck(8'h71);

    // R2 placement: even and odd channels, block bits
    @(negedge clk); txSet = 8'h01; rxSet = 8'h08; brkSet = 8'h20; cntSet = 4'h8; ipcSet = 4'h2;
    tick();
    ioRead(8'h04, "R2 block0");
    ioRead(8'h24, "R2 block1");
    ioRead(8'h44, "R2 block2");
    ioRead(8'h64, "R2 block3");
    @(negedge clk); txSet = 8'h80; brkSet = 8'h40; rxSet = 8'h04;
    tick();
    ioRead(8'h64, "R2 block3 both");
    ioRead(8'h24, "R2 block1 odd rx");

    // R7 read has no side effects, other offsets read 0
    ioRead(8'h64, "R7 reread");
    ioRead(8'h05, "R7 other offset");
    ioRead(8'h20, "R7 other offset");

    // R3 clear and simultaneous set/clear
    @(negedge clk); txClr = 8'hFF; rxClr = 8'hFF; brkClr = 8'hFF; cntClr = 4'hF; ipcClr = 4'hF;
    txSet = 8'h02; txClr[1] = 1'b1;
    tick();
    ioRead(8'h04, "R3 set beats clear");
    ioRead(8'h64, "R3 cleared");
    @(negedge clk); txClr = 8'h02; tick();
    ioRead(8'h04, "R3 clear only");

    // R5 exact latency, R6 mask write
    ioWrite(8'h04, 8'h01);
    @(negedge clk); txSet = 8'h01;
    @(negedge clk); clearInputs();
    chk("R5 line low after first edge", irqReq[0], 0);
    @(negedge clk);
    chk("R5 line high after second edge", irqReq[0], 1);
    chk("R4 other line idle", irqReq[1], 0);
    ioWrite(8'h04, 8'h00);
    @(negedge clk);
    chk("R6 mask cleared drops line", irqReq[0], 0);

    // R4 pairing: block 1 on line 0, block 3 on line 1, block 2 on line 1
    @(negedge clk); rxSet = 8'h08; ipcSet = 4'h8; brkSet = 8'h10; tick();
    ioWrite(8'h24, 8'h20);
    ioWrite(8'h64, 8'h80);
    tick();
    chk("R4 block1 drives line 0", irqReq[0], 1);
    chk("R4 block3 drives line 1", irqReq[1], 1);
    ioWrite(8'h64, 8'h00);
    ioWrite(8'h44, 8'h04);
    tick();
    chk("R4 block2 drives line 1", irqReq[1], 1);
    ioWrite(8'h44, 8'h40);
    tick();
    chk("R4 unmasked bit quiet", irqReq[1], 0);

    // R8 vector load and R9 acknowledge
    @(negedge clk); hostWrData = 8'hA5; idWr = 1; tick();
    ackRead(8'h00, "R9 ack line 0");
    ackRead(8'h02, "R9 ack line 1");
    ackRead(8'h01, "R9 invalid ack");
    ackRead(8'h04, "R9 invalid ack");
    @(negedge clk); hostWrData = 8'h3C; memWr8 = 1; tick();
    ackRead(8'h02, "R8 memory byte vector");
    chk("R9 ack leaves line", irqReq[0], 1);

    // R10 high address space
    ioWrite(8'hE4, 8'hFF);
    tick();
    chk("R10 high write ignored", irqReq[1], 0);
    ioRead(8'h84, "R10 high read zero");
    ioRead(8'h64, "R10 status intact");

    repeat (3) tick();
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule